// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps one private cache coherent with its peers on a shared snooping bus. A small direct-mapped array holds, for each line, a tag, a one-word data copy and one of four coherence states: Modified, Exclusive, Shared or Invalid. The processor side issues one read or write at a time and holds it until the block reports completion. Hits that need no bus traffic finish locally. All other accesses raise a bus request. The request is re-decided in every cycle until a grant arrives. When the victim line is dirty, a write-back goes out first, followed by a read or a read-for-ownership.

The snoop side watches transactions issued by other caches. In the same cycle that an address is on the bus, the block reports on a wired-OR shared line whether it holds a valid copy. If its copy is dirty, it also supplies the word in place of memory. On the next clock edge it downgrades or invalidates the line. When this cache fills a line for a read, it samples the combined shared line at the grant. A low level installs the line as Exclusive, so a later write can upgrade it silently.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `mst_req` and `cpu_done` are low and `mst_cmd` reads 0 (no command). A snoop to any address leaves `snp_shared` low.
- R2: A read that hits a line in Modified, Exclusive or Shared issues no bus request. It raises `cpu_done` for one cycle, in the cycle after the request is accepted, with the cached word on `cpu_rdata`.
- R3: A read miss requests a bus read, code 1, for the requested address. At the grant it installs `bus_fill_data` and returns it. The line becomes Exclusive if `bus_shared_in` is low at the grant and Shared if it is high. `cpu_done` follows in the cycle after the grant.
- R4: A write that hits a line in Modified or Exclusive issues no bus request. The line becomes Modified and holds the written word.
- R5: A write to a line that is Shared or absent requests a read-for-ownership, code 2. At the grant the line becomes Modified and holds the written word.
- R6: When a miss maps onto a line that holds a different address in Modified, the block first requests a write-back, code 3. The write-back carries the victim's full address on `mst_addr` and its word on `mst_data`. The fetch for the new address follows.
- R7: A snooped bus read (1) or read-for-ownership (2) whose address matches a valid line drives `snp_shared` high combinationally in the same cycle. Snooped write-backs (3), the no-command code (0) and non-matching addresses leave it low.
- R8: A snooped read or read-for-ownership that hits a Modified line drives `snp_flush` high with the line's word on `snp_data` in the same cycle. After a read the line becomes Shared. After a read-for-ownership it becomes Invalid.
- R9: A snooped read that hits an Exclusive or Shared line leaves it Shared without a flush. A snooped read-for-ownership makes it Invalid.
- R10: A processor request is not acted upon in any cycle in which `snp_valid` is high. The request is served after the snoop, against the line state the snoop left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address of the access |
| cpu_wdata | input | DW | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, valid with `cpu_done` on reads |
| mst_req | output | 1 | Bus request from this cache |
| mst_cmd | output | 2 | Requested command: 0 none, 1 read, 2 read-for-ownership, 3 write-back |
| mst_addr | output | AW | Address of the requested transaction |
| mst_data | output | DW | Word carried by a write-back |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line from the other caches |
| bus_fill_data | input | DW | Fill word from memory or the owning cache |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `mst_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy of the snooped address |
| snp_flush | output | 1 | This cache supplies the snooped word |
| snp_data | output | DW | Supplied word, zero when not flushing |

## Verification
The checks assume the surrounding bus behaves correctly. `bus_gnt` rises only while `mst_req` is high. A snoop never shares a cycle with this cache's grant. `cpu_req` and its operands stay stable until `cpu_done`. The bench keeps within these assumptions by acting as the arbiter and memory itself: it grants only at a falling edge where it sees a request, presents snoops outside grant cycles, and drops the request on the edge where it observes completion. It places each line into every one of the four states through ordinary traffic. From each state it applies every processor operation and every snoop kind, including dirty victims and a snoop that collides with a pending write.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_EXC = 2'd2,
      LN_MOD = 2'd3
   } line_state_e;

   typedef enum logic [1:0] {
      BC_NONE = 2'd0,
      BC_RD   = 2'd1,
      BC_RDX  = 2'd2,
      BC_WB   = 2'd3
   } bus_cmd_e;

   typedef enum logic [1:0] {
      RQ_IDLE = 2'd0,
      RQ_BUS  = 2'd1,
      RQ_RESP = 2'd2
   } req_phase_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
   import mesi_pkg::*;
#(
   parameter int LINES = 8,
   parameter int IDXW  = 3,
   parameter int TAGW  = 8,
   parameter int DW    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   // lookup port for the processor side
   input  logic [IDXW-1:0]   a_idx,
   output line_state_e       a_st,
   output logic [TAGW-1:0]   a_tag,
   output logic [DW-1:0]     a_data,
   // lookup port for the snoop side
   input  logic [IDXW-1:0]   b_idx,
   output line_state_e       b_st,
   output logic [TAGW-1:0]   b_tag,
   output logic [DW-1:0]     b_data,
   // full-line update from the request sequencer (wins on a clash)
   input  logic              own_we,
   input  logic [IDXW-1:0]   own_idx,
   input  line_state_e       own_st,
   input  logic [TAGW-1:0]   own_tag,
   input  logic [DW-1:0]     own_data,
   // state-only update from the snoop responder
   input  logic              snp_we,
   input  logic [IDXW-1:0]   snp_idx,
   input  line_state_e       snp_st
);

   line_state_e       st_v  [LINES];
   logic [TAGW-1:0]   tag_v [LINES];
   logic [DW-1:0]     dat_v [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_state_e     st_q;
      logic [TAGW-1:0] tag_q;
      logic [DW-1:0]   dat_q;
      logic            own_sel;
      logic            snp_sel;

      assign own_sel = own_we && (own_idx == IDXW'(g));
      assign snp_sel = snp_we && (snp_idx == IDXW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= LN_INV;
            tag_q <= '0;
            dat_q <= '0;
         end else if (own_sel) begin
            st_q  <= own_st;
            tag_q <= own_tag;
            dat_q <= own_data;
         end else if (snp_sel) begin
            st_q  <= snp_st;
         end
      end

      assign st_v[g]  = st_q;
      assign tag_v[g] = tag_q;
      assign dat_v[g] = dat_q;
   end

   assign a_st   = st_v[a_idx];
   assign a_tag  = tag_v[a_idx];
   assign a_data = dat_v[a_idx];
   assign b_st   = st_v[b_idx];
   assign b_tag  = tag_v[b_idx];
   assign b_data = dat_v[b_idx];

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
#(
   parameter int TAGW = 8
) (
   input  logic            snp_valid,
   input  bus_cmd_e        snp_cmd,
   input  logic [TAGW-1:0] snp_tag,
   input  line_state_e     ln_st,
   input  logic [TAGW-1:0] ln_tag,
   output logic            cp_shared,
   output logic            cp_flush,
   output logic            upd_we,
   output line_state_e     upd_st
);

   logic match;

   assign match = snp_valid && (ln_st != LN_INV) && (ln_tag == snp_tag);

   always_comb begin
      cp_shared = 1'b0;
      cp_flush  = 1'b0;
      upd_we    = 1'b0;
      upd_st    = ln_st;
      if (match) begin
         unique case (snp_cmd)
            BC_RD: begin
               cp_shared = 1'b1;
               cp_flush  = (ln_st == LN_MOD);
               upd_we    = (ln_st != LN_SHR);
               upd_st    = LN_SHR;
            end
            BC_RDX: begin
               cp_shared = 1'b1;
               cp_flush  = (ln_st == LN_MOD);
               upd_we    = 1'b1;
               upd_st    = LN_INV;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
   import mesi_pkg::*;
#(
   parameter int AW   = 16,
   parameter int DW   = 32,
   parameter int IDXW = 3,
   parameter int TAGW = 13
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_req,
   input  logic            cpu_wr,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   input  logic            snp_busy,
   input  line_state_e     ln_st,
   input  logic [TAGW-1:0] ln_tag,
   input  logic [DW-1:0]   ln_data,
   input  logic            bus_gnt,
   input  logic            bus_shared_in,
   input  logic [DW-1:0]   bus_fill_data,
   output logic [IDXW-1:0] lk_idx,
   output logic            cpu_done,
   output logic [DW-1:0]   cpu_rdata,
   output logic            mst_req,
   output bus_cmd_e        mst_cmd,
   output logic [AW-1:0]   mst_addr,
   output logic [DW-1:0]   mst_data,
   output logic            own_we,
   output line_state_e     own_st,
   output logic [TAGW-1:0] own_tag,
   output logic [DW-1:0]   own_data
);

   req_phase_e      ph_q, ph_d;
   logic            wr_q;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   wdat_q;
   logic [DW-1:0]   rdat_q, rdat_d;
   logic            latch;

   logic            cur_wr;
   logic [AW-1:0]   cur_addr;
   logic [DW-1:0]   cur_wdata;
   logic [TAGW-1:0] cur_tag;
   logic            hit;
   logic            need_wb;

   always_comb begin
      cur_wr    = (ph_q == RQ_IDLE) ? cpu_wr    : wr_q;
      cur_addr  = (ph_q == RQ_IDLE) ? cpu_addr  : addr_q;
      cur_wdata = (ph_q == RQ_IDLE) ? cpu_wdata : wdat_q;
      lk_idx    = cur_addr[IDXW-1:0];
      cur_tag   = cur_addr[AW-1:IDXW];
      hit       = (ln_st != LN_INV) && (ln_tag == cur_tag);
      need_wb   = (ln_st == LN_MOD) && !hit;
   end

   always_comb begin
      ph_d     = ph_q;
      rdat_d   = rdat_q;
      latch    = 1'b0;
      own_we   = 1'b0;
      own_st   = ln_st;
      own_tag  = ln_tag;
      own_data = ln_data;
      mst_req  = 1'b0;
      mst_cmd  = BC_NONE;
      mst_addr = '0;
      mst_data = '0;
      unique case (ph_q)
         RQ_IDLE: begin
            if (cpu_req && !snp_busy) begin
               if (!cur_wr && hit) begin
                  rdat_d = ln_data;
                  ph_d   = RQ_RESP;
               end else if (cur_wr && hit && (ln_st == LN_MOD || ln_st == LN_EXC)) begin
                  own_we   = 1'b1;
                  own_st   = LN_MOD;
                  own_data = cur_wdata;
                  ph_d     = RQ_RESP;
               end else begin
                  latch = 1'b1;
                  ph_d  = RQ_BUS;
               end
            end
         end
         RQ_BUS: begin
            // the command is re-derived each cycle from the live line state,
            // so a snoop that cleans the victim cancels the write-back
            mst_req = 1'b1;
            if (need_wb) begin
               mst_cmd  = BC_WB;
               mst_addr = {ln_tag, lk_idx};
               mst_data = ln_data;
            end else begin
               mst_cmd  = cur_wr ? BC_RDX : BC_RD;
               mst_addr = cur_addr;
            end
            if (bus_gnt) begin
               own_we = 1'b1;
               if (need_wb) begin
                  own_st = LN_INV;
               end else begin
                  own_tag = cur_tag;
                  ph_d    = RQ_RESP;
                  if (cur_wr) begin
                     own_st   = LN_MOD;
                     own_data = cur_wdata;
                  end else begin
                     own_st   = bus_shared_in ? LN_SHR : LN_EXC;
                     own_data = bus_fill_data;
                     rdat_d   = bus_fill_data;
                  end
               end
            end
         end
         default: ph_d = RQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= RQ_IDLE;
         rdat_q <= '0;
         wr_q   <= 1'b0;
         addr_q <= '0;
         wdat_q <= '0;
      end else begin
         ph_q   <= ph_d;
         rdat_q <= rdat_d;
         if (latch) begin
            wr_q   <= cpu_wr;
            addr_q <= cpu_addr;
            wdat_q <= cpu_wdata;
         end
      end
   end

   assign cpu_done  = (ph_q == RQ_RESP);
   assign cpu_rdata = rdat_q;

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
   import mesi_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int LINES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_wr,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_done,
   output logic [DW-1:0] cpu_rdata,
   output logic          mst_req,
   output logic [1:0]    mst_cmd,
   output logic [AW-1:0] mst_addr,
   output logic [DW-1:0] mst_data,
   input  logic          bus_gnt,
   input  logic          bus_shared_in,
   input  logic [DW-1:0] bus_fill_data,
   input  logic          snp_valid,
   input  logic [1:0]    snp_cmd,
   input  logic [AW-1:0] snp_addr,
   output logic          snp_shared,
   output logic          snp_flush,
   output logic [DW-1:0] snp_data
);

   localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1;
   localparam int TAGW = AW - IDXW;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("mesi_snoop_ctrl: LINES must be a power of two of at least 2");
   end
   if (TAGW < 1) begin : g_bad_aw
      $error("mesi_snoop_ctrl: AW must exceed the index width");
   end
   if (DW < 1) begin : g_bad_dw
      $error("mesi_snoop_ctrl: DW must be positive");
   end

   logic [IDXW-1:0] lk_idx;
   line_state_e     a_st, b_st;
   logic [TAGW-1:0] a_tag, b_tag;
   logic [DW-1:0]   a_data, b_data;
   logic            own_we;
   line_state_e     own_st;
   logic [TAGW-1:0] own_tag;
   logic [DW-1:0]   own_data;
   logic            upd_we;
   line_state_e     upd_st;
   logic            cp_flush;
   bus_cmd_e        req_cmd;

   mesi_line_store #(
      .LINES (LINES),
      .IDXW  (IDXW),
      .TAGW  (TAGW),
      .DW    (DW)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_idx    (lk_idx),
      .a_st     (a_st),
      .a_tag    (a_tag),
      .a_data   (a_data),
      .b_idx    (snp_addr[IDXW-1:0]),
      .b_st     (b_st),
      .b_tag    (b_tag),
      .b_data   (b_data),
      .own_we   (own_we),
      .own_idx  (lk_idx),
      .own_st   (own_st),
      .own_tag  (own_tag),
      .own_data (own_data),
      .snp_we   (upd_we),
      .snp_idx  (snp_addr[IDXW-1:0]),
      .snp_st   (upd_st)
   );

   mesi_snoop_resp #(
      .TAGW (TAGW)
   ) u_snoop (
      .snp_valid (snp_valid),
      .snp_cmd   (bus_cmd_e'(snp_cmd)),
      .snp_tag   (snp_addr[AW-1:IDXW]),
      .ln_st     (b_st),
      .ln_tag    (b_tag),
      .cp_shared (snp_shared),
      .cp_flush  (cp_flush),
      .upd_we    (upd_we),
      .upd_st    (upd_st)
   );

   mesi_req_fsm #(
      .AW   (AW),
      .DW   (DW),
      .IDXW (IDXW),
      .TAGW (TAGW)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_wr        (cpu_wr),
      .cpu_addr      (cpu_addr),
      .cpu_wdata     (cpu_wdata),
      .snp_busy      (snp_valid),
      .ln_st         (a_st),
      .ln_tag        (a_tag),
      .ln_data       (a_data),
      .bus_gnt       (bus_gnt),
      .bus_shared_in (bus_shared_in),
      .bus_fill_data (bus_fill_data),
      .lk_idx        (lk_idx),
      .cpu_done      (cpu_done),
      .cpu_rdata     (cpu_rdata),
      .mst_req       (mst_req),
      .mst_cmd       (req_cmd),
      .mst_addr      (mst_addr),
      .mst_data      (mst_data),
      .own_we        (own_we),
      .own_st        (own_st),
      .own_tag       (own_tag),
      .own_data      (own_data)
   );

   assign mst_cmd   = req_cmd;
   assign snp_flush = cp_flush;
   assign snp_data  = cp_flush ? b_data : '0;

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_done,
   input logic       mst_req,
   input logic [1:0] mst_cmd,
   input logic       bus_gnt,
   input logic       snp_valid,
   input logic       snp_shared,
   input logic       snp_flush
);

   // R1: without a request the command lines read "none"
   p_idle_cmd_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mst_req |-> mst_cmd == 2'd0);

   // R3: a raised request always names a real command
   p_req_has_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mst_req |-> mst_cmd != 2'd0);

   // R2: completion is a single-cycle pulse
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   // R3: a granted fetch completes in the following cycle
   p_fill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_req && bus_gnt && mst_cmd != 2'd3) |=> cpu_done);

   // R6: a granted write-back is followed by a fetch request
   p_wb_then_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_req && bus_gnt && mst_cmd == 2'd3) |=> (mst_req && mst_cmd != 2'd3));

   // R8: supplying data implies holding a copy
   p_flush_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> snp_shared);

   // R10: a snoop cycle never lets a processor access finish next
   p_snoop_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !bus_gnt) |=> !cpu_done);

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_done   (cpu_done),
   .mst_req    (mst_req),
   .mst_cmd    (mst_cmd),
   .bus_gnt    (bus_gnt),
   .snp_valid  (snp_valid),
   .snp_shared (snp_shared),
   .snp_flush  (snp_flush)
);

// File: tb/sim_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_snoop_ctrl;

   localparam int AW    = 6;
   localparam int DW    = 8;
   localparam int LINES = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_wr = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_done;
   logic [DW-1:0] cpu_rdata;
   logic          mst_req;
   logic [1:0]    mst_cmd;
   logic [AW-1:0] mst_addr;
   logic [DW-1:0] mst_data;
   logic          bus_gnt = 1'b0, bus_shared_in = 1'b0;
   logic [DW-1:0] bus_fill_data = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_shared, snp_flush;
   logic [DW-1:0] snp_data;

   always #10 clk = ~clk;

   mesi_snoop_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .mst_req(mst_req), .mst_cmd(mst_cmd), .mst_addr(mst_addr), .mst_data(mst_data),
      .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in), .bus_fill_data(bus_fill_data),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data)
   );

   int  n_chk = 0, n_fail = 0;
   bit  finished = 1'b0;
   logic [7:0] mem [64];
   int  g_n, g_rd, g_lat, g_d0, g_sfl, g_ssh, g_sdat;
   int  g_cmd [2];
   int  g_addr [2];
   int  g_dat [2];

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // one processor access; the bench arbitrates, serves memory and records bus commands
   task automatic cpu_op(input bit wr, input int addr, input int wd, input bit sh, input bit with_snp);
      bit done;
      done = 1'b0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = wr; cpu_addr = addr[5:0]; cpu_wdata = wd[7:0];
      g_n = 0; g_lat = 0; g_d0 = 0;
      if (with_snp) begin
         snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = addr[5:0];
         #2;
         g_sfl = snp_flush; g_sdat = snp_data;
         if (snp_flush) mem[addr] = snp_data;
      end
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         bus_gnt = 1'b0; snp_valid = 1'b0;
         if (k == 0) g_d0 = cpu_done;
         if (cpu_done) begin
            g_rd = cpu_rdata; g_lat = k; done = 1'b1;
            break;
         end
         if (mst_req) begin
            if (g_n < 2) begin
               g_cmd[g_n] = mst_cmd; g_addr[g_n] = mst_addr; g_dat[g_n] = mst_data;
            end
            g_n++;
            if (mst_cmd == 2'd3) mem[mst_addr] = mst_data;
            bus_fill_data = mem[mst_addr];
            bus_shared_in = sh;
            bus_gnt = 1'b1;
         end
      end
      cpu_req = 1'b0;
      if (!done) chk("R10", "access completion", 0, 1);
   endtask

   task automatic snoop(input int cmd, input int addr);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = cmd[1:0]; snp_addr = addr[5:0];
      #2;
      g_ssh = snp_shared; g_sfl = snp_flush; g_sdat = snp_data;
      if (snp_flush) mem[addr] = snp_data;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   // st: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
   task automatic set_state(input int st, input int a, input int wv);
      cpu_op(1'b0, a, 0, 1'b1, 1'b0);
      snoop(2, a);
      case (st)
         1: cpu_op(1'b0, a, 0, 1'b1, 1'b0);
         2: cpu_op(1'b0, a, 0, 1'b0, 1'b0);
         3: cpu_op(1'b1, a, wv, 1'b1, 1'b0);
         default: ;
      endcase
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 8'(i * 5 + 3);
      repeat (3) @(negedge clk);
      chk("R1", "done in reset", cpu_done, 0);
      chk("R1", "request in reset", mst_req, 0);
      chk("R1", "command in reset", mst_cmd, 0);
      rst_n = 1'b1;
      for (int a = 0; a < 64; a += 13) begin
         snoop(1, a);
         chk("R1", "shared after reset", g_ssh, 0);
      end

      for (int st = 0; st < 4; st++) begin
         for (int op = 0; op < 7; op++) begin
            int idx, ta, a, b, wv, ev, eb, sh, d;
            idx = (st * 7 + op) % 4;
            ta  = (st * 3 + op) % 16;
            a   = ta * 4 + idx;
            b   = (ta ^ 5) * 4 + idx;
            wv  = 8'h80 + st * 16 + op;
            set_state(st, a, wv);
            ev  = (st == 3) ? wv : int'(mem[a]);
            case (op)
               0: begin
                  cpu_op(1'b0, a, 0, 1'b0, 1'b0);
                  chk((st == 0) ? "R3" : "R2", "read bus count", g_n, (st == 0) ? 1 : 0);
                  if (st == 0) begin
                     chk("R3", "read miss cmd", g_cmd[0], 1);
                     chk("R3", "read miss addr", g_addr[0], a);
                  end
                  chk("R2", "read data", g_rd, ev);
                  chk("R2", "done latency", g_lat, g_n);
               end
               1: begin
                  d = wv ^ 8'h55;
                  cpu_op(1'b1, a, d, 1'b0, 1'b0);
                  chk((st >= 2) ? "R4" : "R5", "write bus count", g_n, (st < 2) ? 1 : 0);
                  if (st < 2) chk("R5", "write cmd", g_cmd[0], 2);
                  cpu_op(1'b0, a, 0, 1'b0, 1'b0);
                  chk("R4", "reread bus count", g_n, 0);
                  chk("R5", "reread data", g_rd, d);
                  snoop(1, a);
                  chk("R4", "line modified", g_sfl, 1);
                  chk("R8", "flush word", g_sdat, d);
               end
               2: begin
                  eb = mem[b];
                  sh = st % 2;
                  cpu_op(1'b0, b, 0, sh[0], 1'b0);
                  if (st == 3) begin
                     chk("R6", "victim bus count", g_n, 2);
                     chk("R6", "wb cmd", g_cmd[0], 3);
                     chk("R6", "wb addr", g_addr[0], a);
                     chk("R6", "wb data", g_dat[0], wv);
                     chk("R6", "fetch after wb", g_cmd[1], 1);
                  end else begin
                     chk("R3", "conflict bus count", g_n, 1);
                     chk("R3", "conflict cmd", g_cmd[0], 1);
                  end
                  chk("R3", "fill data", g_rd, eb);
                  cpu_op(1'b1, b, 8'h11, 1'b0, 1'b0);
                  chk("R3", "fill state by shared line", g_n, sh);
               end
               3: begin
                  cpu_op(1'b1, b, 8'h22, 1'b0, 1'b0);
                  if (st == 3) begin
                     chk("R6", "victim bus count", g_n, 2);
                     chk("R6", "wb cmd", g_cmd[0], 3);
                     chk("R6", "wb addr", g_addr[0], a);
                     chk("R6", "wb data", g_dat[0], wv);
                     chk("R5", "rdx after wb", g_cmd[1], 2);
                  end else begin
                     chk("R5", "write miss count", g_n, 1);
                     chk("R5", "write miss cmd", g_cmd[0], 2);
                  end
               end
               4: begin
                  snoop(1, a);
                  chk("R7", "shared on read snoop", g_ssh, (st != 0) ? 1 : 0);
                  chk("R8", "flush on read snoop", g_sfl, (st == 3) ? 1 : 0);
                  if (st == 3) chk("R8", "flush word", g_sdat, wv);
                  cpu_op(1'b1, a, 8'h44, 1'b0, 1'b0);
                  chk("R9", "not owned after read snoop", g_n, 1);
                  chk("R9", "rdx after read snoop", g_cmd[0], 2);
               end
               5: begin
                  snoop(2, a);
                  chk("R7", "shared on rdx snoop", g_ssh, (st != 0) ? 1 : 0);
                  chk("R8", "flush on rdx snoop", g_sfl, (st == 3) ? 1 : 0);
                  cpu_op(1'b0, a, 0, 1'b0, 1'b0);
                  chk("R9", "invalid after rdx snoop", g_n, 1);
                  chk("R9", "refetch cmd", g_cmd[0], 1);
                  chk("R8", "memory took flushed word", g_rd, ev);
               end
               default: begin
                  snoop(3, a);
                  chk("R7", "no shared on wb snoop", g_ssh, 0);
                  chk("R7", "no flush on wb snoop", g_sfl, 0);
                  cpu_op(1'b0, a, 0, 1'b0, 1'b0);
                  chk("R7", "line kept after wb snoop", g_n, (st == 0) ? 1 : 0);
                  chk("R7", "data kept after wb snoop", g_rd, ev);
               end
            endcase
         end
      end

      // snoop colliding with a pending write to a Modified line
      set_state(3, 6'h2A, 8'h5C);
      cpu_op(1'b1, 6'h2A, 8'h33, 1'b0, 1'b1);
      chk("R8", "flush during stalled write", g_sfl, 1);
      chk("R8", "flushed word", g_sdat, 8'h5C);
      chk("R10", "no completion in snoop cycle", g_d0, 0);
      chk("R10", "write served after snoop", g_n, 1);
      chk("R10", "write needs rdx", g_cmd[0], 2);
      cpu_op(1'b0, 6'h2A, 0, 1'b0, 1'b0);
      chk("R10", "write landed", g_rd, 8'h33);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule